// File: doc/BRIEF.md
# Sv32 Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table kept in memory. A requester hands it a virtual address, an access code (load, store or fetch) and the current privilege level. The block samples the root table pointer from the translation CSR value at that moment. It then reads one or two 32-bit page table entries through a single read port with a fixed one-cycle latency. It answers with a one-cycle response that holds either a physical address or a page fault tagged with the access code of the request.

An entry with none of its execute, write or read bits set is a link to the next table level. Any other valid entry is a leaf. A leaf found at the first level maps a 4 MiB superpage, and the low half of its frame number must be zero. Permission, user/supervisor, accessed and dirty checks are made on the leaf. The block never updates an entry. A missing accessed or dirty bit is reported as a fault so that software can set the bit. Only one walk runs at a time.

Top module: `sv32_walker`

## Requirements
- R1: After reset, and until a request arrives, `req_ready` is 1 and `resp_valid` and `mem_rd_en` are 0.
- R2: A request is taken in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 until the response. The first entry read is issued in the cycle after acceptance, and read data is used in the cycle after `mem_rd_en`. `resp_valid` is a one-cycle pulse: 3 cycles after acceptance for a one-read walk, 5 cycles after for a two-read walk.
- R3: The first read address is satp[21:0]·4096 + va[31:22]·4, kept to its low PA_W bits (PA_W = 26 by default, a 64 MiB space).
- R4: Entry layout: bit0 valid, bit1 read, bit2 write, bit3 execute, bit4 user, bit6 accessed, bit7 dirty, bits 31:10 frame number. An entry at either level with valid = 0, or with write = 1 and read = 0, faults.
- R5: An entry with execute, write and read all 0 at the first level causes a second read at frame·4096 + va[21:12]·4 (low PA_W bits). Such an entry at the second level faults.
- R6: A first-level leaf whose bits 19:10 are nonzero faults as misaligned. Otherwise the physical address is {entry[31:20], va[21:0]}, kept to PA_W bits.
- R7: A second-level leaf gives the physical address {entry[31:10], va[11:0]}, kept to PA_W bits.
- R8: Access code 0 (load) needs read = 1, code 1 (store) needs write = 1, code 2 (fetch) needs execute = 1. Code 3 always faults.
- R9: `req_priv` = 0 (user) needs user = 1 in the leaf. `req_priv` = 1 (supervisor) needs user = 0.
- R10: A leaf with accessed = 0 faults. A store to a leaf with dirty = 0 faults. Loads and fetches ignore dirty.
- R11: Every response returns the request's access code on `resp_acc`. A fault sets `resp_fault` = 1 with `resp_paddr` = 0. A success sets `resp_fault` = 0.
- R12: satp bits 31:22 have no effect. The address, access code, privilege and satp are sampled at acceptance, so changes after that do not alter the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access code: 0 load, 1 store, 2 fetch, 3 none |
| req_priv | input | 1 | 0 user, 1 supervisor |
| satp | input | 32 | Translation CSR value; bits 21:0 give the root frame |
| mem_rd_en | output | 1 | Entry read strobe |
| mem_rd_addr | output | PA_W | Byte address of the entry to read |
| mem_rd_data | input | 32 | Entry data, valid the cycle after `mem_rd_en` |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_fault | output | 1 | Response is a page fault |
| resp_acc | output | 2 | Access code of the answered request |
| resp_paddr | output | PA_W | Physical address; 0 on a fault |

## Verification
The bench targets the cases a walker most often gets wrong. A link entry met at the second level would leave a design that walks again hung, or reading a wild address. A superpage whose low frame bits are set would be wrongly mapped if the misalignment test were missing. The reserved write-without-read code must fault even when valid is set. A store to a clean page must fault while a load from the same page succeeds. The user bit must be tested in both directions. The bench also changes the request inputs and satp right after acceptance, so a design that reads them live would produce wrong addresses. Root frames and leaf frames above 64 MiB check that addresses wrap to PA_W bits rather than spill into wider logic.

// File: rtl/sv32_pkg.sv
package sv32_pkg;

    localparam int unsigned VA_W    = 32;
    localparam int unsigned OFF_W   = 12;
    localparam int unsigned VPN_W   = 10;
    localparam int unsigned PPN_W   = 22;
    localparam int unsigned PTE_W   = 32;
    localparam int unsigned FULL_PA = PPN_W + OFF_W;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_NONE  = 2'd3
    } acc_e;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic [1:0]       rsw;
        logic             d;
        logic             a;
        logic             g;
        logic             u;
        logic             x;
        logic             w;
        logic             r;
        logic             v;
    } pte_t;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD1  = 3'd1,
        ST_WT1  = 3'd2,
        ST_RD0  = 3'd3,
        ST_WT0  = 3'd4
    } walk_st_e;

    typedef enum logic [1:0] {
        PTE_NEXT  = 2'd0,
        PTE_LEAF  = 2'd1,
        PTE_FAULT = 2'd2
    } pte_kind_e;

endpackage

// File: rtl/sv32_pte_check.sv
module sv32_pte_check
    import sv32_pkg::*;
(
    input  pte_t      pte,
    input  logic      top_level,
    input  acc_e      acc,
    input  logic      sup,
    output pte_kind_e kind
);

    logic bad_enc;
    logic is_link;
    logic misalign;
    logic perm_ok;
    logic mode_ok;
    logic ad_ok;
    logic unused_pte_bits;

    assign unused_pte_bits = ^{pte.rsw, pte.g, pte.ppn[PPN_W-1:VPN_W]};

    always_comb begin
        bad_enc  = !pte.v || (pte.w && !pte.r);
        is_link  = !pte.x && !pte.w && !pte.r;
        misalign = top_level && (pte.ppn[VPN_W-1:0] != '0);
        unique case (acc)
            ACC_LOAD:  perm_ok = pte.r;
            ACC_STORE: perm_ok = pte.w;
            ACC_FETCH: perm_ok = pte.x;
            default:   perm_ok = 1'b0;
        endcase
        mode_ok = sup ? !pte.u : pte.u;
        ad_ok   = pte.a && ((acc != ACC_STORE) || pte.d);

        if (bad_enc) begin
            kind = PTE_FAULT;
        end else if (is_link) begin
            kind = top_level ? PTE_NEXT : PTE_FAULT;
        end else if (!misalign && perm_ok && mode_ok && ad_ok) begin
            kind = PTE_LEAF;
        end else begin
            kind = PTE_FAULT;
        end
    end

endmodule

// File: rtl/sv32_addr_calc.sv
module sv32_addr_calc
    import sv32_pkg::*;
#(
    parameter int unsigned PA_W = 26
) (
    input  logic [PPN_W-1:0] root_ppn,
    input  logic [PPN_W-1:0] link_ppn,
    input  logic [PPN_W-1:0] leaf_ppn,
    input  logic [VA_W-1:0]  vaddr,
    output logic [PA_W-1:0]  l1_addr,
    output logic [PA_W-1:0]  l0_addr,
    output logic [PA_W-1:0]  super_pa,
    output logic [PA_W-1:0]  page_pa
);

    localparam int unsigned VPN1_LO = OFF_W + VPN_W;

    logic [VPN_W-1:0]   vpn1;
    logic [VPN_W-1:0]   vpn0;
    logic [OFF_W-1:0]   offs;
    logic [FULL_PA-1:0] l1_full;
    logic [FULL_PA-1:0] l0_full;
    logic [FULL_PA-1:0] sp_full;
    logic [FULL_PA-1:0] pg_full;

    always_comb begin
        vpn1    = vaddr[VA_W-1:VPN1_LO];
        vpn0    = vaddr[VPN1_LO-1:OFF_W];
        offs    = vaddr[OFF_W-1:0];
        l1_full = {root_ppn, vpn1, 2'b00};
        l0_full = {link_ppn, vpn0, 2'b00};
        sp_full = {leaf_ppn[PPN_W-1:VPN_W], vpn0, offs};
        pg_full = {leaf_ppn, offs};
        l1_addr  = PA_W'(l1_full);
        l0_addr  = PA_W'(l0_full);
        super_pa = PA_W'(sp_full);
        page_pa  = PA_W'(pg_full);
    end

endmodule

// File: rtl/sv32_walker.sv
module sv32_walker
    import sv32_pkg::*;
#(
    parameter int unsigned PA_W = 26
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [31:0]     req_vaddr,
    input  logic [1:0]      req_acc,
    input  logic            req_priv,
    input  logic [31:0]     satp,
    output logic            mem_rd_en,
    output logic [PA_W-1:0] mem_rd_addr,
    input  logic [31:0]     mem_rd_data,
    output logic            resp_valid,
    output logic            resp_fault,
    output logic [1:0]      resp_acc,
    output logic [PA_W-1:0] resp_paddr
);

    typedef struct packed {
        walk_st_e         st;
        logic [VA_W-1:0]  va;
        acc_e             acc;
        logic             sup;
        logic [PPN_W-1:0] root;
        logic [PPN_W-1:0] link;
        logic             rv;
        logic             rf;
        acc_e             racc;
        logic [PA_W-1:0]  rpa;
    } walk_state_t;

    walk_state_t state_d, state_q;

    pte_t            pte_in;
    pte_kind_e       kind;
    logic [PA_W-1:0] l1_addr;
    logic [PA_W-1:0] l0_addr;
    logic [PA_W-1:0] super_pa;
    logic [PA_W-1:0] page_pa;
    logic            unused_satp_hi;

    assign pte_in         = pte_t'(mem_rd_data);
    assign unused_satp_hi = ^satp[31:PPN_W];

    sv32_pte_check u_check (
        .pte       (pte_in),
        .top_level (state_q.st == ST_WT1),
        .acc       (state_q.acc),
        .sup       (state_q.sup),
        .kind      (kind)
    );

    sv32_addr_calc #(.PA_W(PA_W)) u_addr (
        .root_ppn (state_q.root),
        .link_ppn (state_q.link),
        .leaf_ppn (pte_in.ppn),
        .vaddr    (state_q.va),
        .l1_addr  (l1_addr),
        .l0_addr  (l0_addr),
        .super_pa (super_pa),
        .page_pa  (page_pa)
    );

    always_comb begin
        state_d    = state_q;
        state_d.rv = 1'b0;
        unique case (state_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d.st   = ST_RD1;
                    state_d.va   = req_vaddr;
                    state_d.acc  = acc_e'(req_acc);
                    state_d.sup  = req_priv;
                    state_d.root = satp[PPN_W-1:0];
                end
            end
            ST_RD1: state_d.st = ST_WT1;
            ST_WT1: begin
                unique case (kind)
                    PTE_NEXT: begin
                        state_d.st   = ST_RD0;
                        state_d.link = pte_in.ppn;
                    end
                    PTE_LEAF: begin
                        state_d.st   = ST_IDLE;
                        state_d.rv   = 1'b1;
                        state_d.rf   = 1'b0;
                        state_d.racc = state_q.acc;
                        state_d.rpa  = super_pa;
                    end
                    default: begin
                        state_d.st   = ST_IDLE;
                        state_d.rv   = 1'b1;
                        state_d.rf   = 1'b1;
                        state_d.racc = state_q.acc;
                        state_d.rpa  = '0;
                    end
                endcase
            end
            ST_RD0: state_d.st = ST_WT0;
            ST_WT0: begin
                state_d.st   = ST_IDLE;
                state_d.rv   = 1'b1;
                state_d.racc = state_q.acc;
                if (kind == PTE_LEAF) begin
                    state_d.rf  = 1'b0;
                    state_d.rpa = page_pa;
                end else begin
                    state_d.rf  = 1'b1;
                    state_d.rpa = '0;
                end
            end
            default: state_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign req_ready   = (state_q.st == ST_IDLE);
    assign mem_rd_en   = (state_q.st == ST_RD1) || (state_q.st == ST_RD0);
    assign mem_rd_addr = (state_q.st == ST_RD0) ? l0_addr : l1_addr;
    assign resp_valid  = state_q.rv;
    assign resp_fault  = state_q.rf;
    assign resp_acc    = state_q.racc;
    assign resp_paddr  = state_q.rpa;

endmodule

// File: rtl/sv32_walker_chk.sv
module sv32_walker_chk #(
    parameter int unsigned PA_W = 26
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [31:0]     req_vaddr,
    input logic [1:0]      req_acc,
    input logic            mem_rd_en,
    input logic [PA_W-1:0] mem_rd_addr,
    input logic            resp_valid,
    input logic            resp_fault,
    input logic [1:0]      resp_acc,
    input logic [PA_W-1:0] resp_paddr
);

    logic [31:0] va_seen_q;
    logic [1:0]  acc_seen_q;
    logic        unused_chk;

    assign unused_chk = ^{mem_rd_addr[PA_W-1:12], req_vaddr[21:12]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_seen_q  <= '0;
            acc_seen_q <= '0;
        end else if (req_valid && req_ready) begin
            va_seen_q  <= req_vaddr;
            acc_seen_q <= req_acc;
        end
    end

    // R2
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R2
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !req_ready);

    // R2
    issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_rd_en && !req_ready));

    // R2
    rd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R3
    l1_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_rd_addr[11:0] == {$past(req_vaddr[31:22]), 2'b00}));

    // R11
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> (resp_paddr == '0));

    // R11
    acc_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_acc == acc_seen_q));

    // R7
    offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_fault) |-> (resp_paddr[11:0] == va_seen_q[11:0]));

endmodule

bind sv32_walker sv32_walker_chk #(.PA_W(PA_W)) u_walker_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_vaddr   (req_vaddr),
    .req_acc     (req_acc),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .resp_valid  (resp_valid),
    .resp_fault  (resp_fault),
    .resp_acc    (resp_acc),
    .resp_paddr  (resp_paddr)
);

// File: tb/tb_sv32_walker.sv
`timescale 1ns/1ps
module tb_sv32_walker;

    localparam int unsigned PA_W = 26;
    localparam logic [7:0] FV = 8'h01, FR = 8'h02, FW = 8'h04, FX = 8'h08,
                           FU = 8'h10, FA = 8'h40, FD = 8'h80;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [31:0]     req_vaddr = '0;
    logic [1:0]      req_acc = '0;
    logic            req_priv = 1'b0;
    logic [31:0]     satp = '0;
    logic            mem_rd_en;
    logic [PA_W-1:0] mem_rd_addr;
    logic [31:0]     mem_rd_data = '0;
    logic            resp_valid;
    logic            resp_fault;
    logic [1:0]      resp_acc;
    logic [PA_W-1:0] resp_paddr;

    int nchecks = 0;
    int nerrors = 0;
    logic [31:0] mem [int];

    always #4 clk = ~clk;

    sv32_walker #(.PA_W(PA_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_acc(req_acc), .req_priv(req_priv), .satp(satp),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_acc(resp_acc),
        .resp_paddr(resp_paddr)
    );

    function automatic logic [31:0] rd(input logic [PA_W-1:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= rd(mem_rd_addr);
    end

    function automatic logic [31:0] mkpte(input logic [21:0] ppn, input logic [7:0] fl);
        return {ppn, 2'b00, fl};
    endfunction

    task automatic put(input int a, input logic [31:0] v);
        mem[a] = v;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchecks++;
        if (!ok) begin
            nerrors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference walk, built from the requirement list.
    function automatic void model(input logic [31:0] va, input logic [1:0] acc,
                                  input logic priv, input logic [31:0] sp,
                                  output logic flt, output logic [PA_W-1:0] pa,
                                  output int nrd, output logic [PA_W-1:0] a1,
                                  output logic [PA_W-1:0] a0);
        logic [63:0] addr;
        logic [31:0] pte;
        bit need;
        flt = 1'b0; pa = '0; a0 = '0; nrd = 1;
        addr = 64'(sp[21:0]) * 4096 + 64'(va[31:22]) * 4;
        a1 = addr[PA_W-1:0];
        pte = rd(a1);
        for (int lvl = 1; lvl >= 0; lvl--) begin
            if (!pte[0] || (pte[2] && !pte[1])) begin flt = 1'b1; return; end
            if (pte[3:1] == 3'b000) begin
                if (lvl == 0) begin flt = 1'b1; return; end
                addr = 64'(pte[31:10]) * 4096 + 64'(va[21:12]) * 4;
                a0 = addr[PA_W-1:0];
                nrd = 2;
                pte = rd(a0);
                continue;
            end
            if (lvl == 1 && pte[19:10] != 10'd0) begin flt = 1'b1; return; end
            case (acc)
                2'd0: need = pte[1];
                2'd1: need = pte[2];
                2'd2: need = pte[3];
                default: need = 1'b0;
            endcase
            if (!need) begin flt = 1'b1; return; end
            if (priv ? pte[4] : !pte[4]) begin flt = 1'b1; return; end
            if (!pte[6] || (acc == 2'd1 && !pte[7])) begin flt = 1'b1; return; end
            if (lvl == 1) addr = 64'(pte[31:20]) * 4194304 + 64'(va[21:0]);
            else          addr = 64'(pte[31:10]) * 4096 + 64'(va[11:0]);
            pa = addr[PA_W-1:0];
            return;
        end
    endfunction

    // Runs one request and compares every cycle against the model.
    task automatic run(input logic [31:0] va, input logic [1:0] acc, input logic priv,
                       input logic [31:0] sp, input string tag);
        logic flt;
        logic [PA_W-1:0] pa, a1, a0;
        int nrd;
        model(va, acc, priv, sp, flt, pa, nrd, a1, a0);
        chk(req_ready == 1'b1, "R2", {tag, " ready before"}, req_ready, 1);
        req_valid = 1'b1; req_vaddr = va; req_acc = acc; req_priv = priv; satp = sp;
        @(negedge clk);
        req_valid = 1'b0; req_vaddr = ~va; req_acc = ~acc; req_priv = ~priv; satp = ~sp;
        chk(mem_rd_en == 1'b1, "R2", {tag, " rd1 strobe"}, mem_rd_en, 1);
        chk(req_ready == 1'b0, "R2", {tag, " busy"}, req_ready, 0);
        chk(mem_rd_addr == a1, "R3", {tag, " l1 addr"}, mem_rd_addr, a1);
        chk(resp_valid == 1'b0, "R2", {tag, " early resp"}, resp_valid, 0);
        @(negedge clk);
        chk(mem_rd_en == 1'b0 && resp_valid == 1'b0, "R2", {tag, " wait1"},
            {mem_rd_en, resp_valid}, 0);
        if (nrd == 2) begin
            @(negedge clk);
            chk(mem_rd_en == 1'b1, "R5", {tag, " rd0 strobe"}, mem_rd_en, 1);
            chk(mem_rd_addr == a0, "R5", {tag, " l0 addr"}, mem_rd_addr, a0);
            @(negedge clk);
            chk(mem_rd_en == 1'b0 && resp_valid == 1'b0, "R2", {tag, " wait0"},
                {mem_rd_en, resp_valid}, 0);
        end
        @(negedge clk);
        chk(resp_valid == 1'b1, "R2", {tag, " resp pulse"}, resp_valid, 1);
        chk(resp_fault == flt, "R11", {tag, " fault"}, resp_fault, flt);
        chk(resp_acc == acc, "R11", {tag, " acc"}, resp_acc, acc);
        chk(resp_paddr == pa, "R11", {tag, " paddr"}, resp_paddr, pa);
        chk(req_ready == 1'b1, "R2", {tag, " ready after"}, req_ready, 1);
        @(negedge clk);
        chk(resp_valid == 1'b0, "R2", {tag, " pulse end"}, resp_valid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerrors++;
        $display("FAIL watchdog actual=%0d expected=%0d", nchecks, 0);
        $display("CHECKS %0d ERRORS %0d", nchecks, nerrors);
        $finish;
    end

    initial begin
        logic [31:0] sp;
        sp = 32'h0000_0001;
        // Directed tables: root at 0x1000, level-0 table at 0x2000.
        put(32'h1004, mkpte({12'h005, 10'h000}, FR | FA | FV));
        put(32'h1008, mkpte({12'h006, 10'h003}, FR | FA | FV));
        put(32'h100C, mkpte(22'h2, FV));
        put(32'h1010, 32'h0);
        put(32'h1014, mkpte({12'h007, 10'h000}, FW | FA | FV));
        put(32'h1018, mkpte({12'h008, 10'h000}, FX | FU | FA | FV));
        put(32'h2000 + 5*4,  mkpte(22'h123, FR | FW | FU | FA | FD | FV));
        put(32'h2000 + 6*4,  mkpte(22'h124, FR | FW | FU | FA | FV));
        put(32'h2000 + 7*4,  mkpte(22'h125, FR | FU | FA));
        put(32'h2000 + 8*4,  mkpte(22'h3,   FV));
        put(32'h2000 + 9*4,  mkpte(22'h126, FR | FX | FA | FV));
        put(32'h2000 + 10*4, mkpte(22'h127, FR | FW | FU | FV));
        put(32'h2000 + 11*4, mkpte(22'h128, FW | FA | FV));
        put(32'h2000 + 12*4, mkpte(22'h3FFFFF, FR | FU | FA | FV));

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
        chk(resp_valid == 1'b0, "R1", "resp in reset", resp_valid, 0);
        chk(mem_rd_en == 1'b0, "R1", "rd in reset", mem_rd_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && resp_valid == 1'b0 && mem_rd_en == 1'b0, "R1",
            "idle after reset", {req_ready, resp_valid, mem_rd_en}, 3'b100);

        run(32'h0045_6789, 2'd0, 1'b1, sp, "R6 superpage load");
        chk(resp_paddr == 26'h1456789, "R6", "superpage pa literal", 0, 0);
        run(32'h0080_1234, 2'd0, 1'b1, sp, "R6 misaligned superpage");
        run(32'h00C0_5ABC, 2'd0, 1'b0, sp, "R7 user load");
        run(32'h00C0_5ABC, 2'd1, 1'b0, sp, "R8 user store ok");
        run(32'h00C0_5ABC, 2'd2, 1'b0, sp, "R8 fetch no X");
        run(32'h00C0_6010, 2'd1, 1'b0, sp, "R10 store clean page");
        run(32'h00C0_6010, 2'd0, 1'b0, sp, "R10 load clean page");
        run(32'h00C0_7000, 2'd0, 1'b0, sp, "R4 invalid level0");
        run(32'h00C0_8000, 2'd0, 1'b0, sp, "R5 link at level0");
        run(32'h00C0_9444, 2'd2, 1'b1, sp, "R9 supervisor fetch");
        run(32'h00C0_9444, 2'd0, 1'b0, sp, "R9 user on sup page");
        run(32'h00C0_A000, 2'd0, 1'b0, sp, "R10 accessed clear");
        run(32'h00C0_B000, 2'd1, 1'b0, sp, "R4 write-only reserved");
        run(32'h00C0_CFFF, 2'd0, 1'b0, sp, "R7 wide frame truncated");
        run(32'h0100_0000, 2'd0, 1'b1, sp, "R4 invalid level1");
        run(32'h0140_0000, 2'd1, 1'b1, sp, "R4 reserved level1");
        run(32'h0180_0040, 2'd2, 1'b0, sp, "R9 user fetch superpage");
        run(32'h0180_0040, 2'd2, 1'b1, sp, "R9 sup on user page");
        run(32'h0180_0040, 2'd3, 1'b0, sp, "R8 access code 3");
        run(32'h0045_6789, 2'd0, 1'b1, 32'hFFC0_0001, "R12 satp high bits");
        run(32'h0045_6789, 2'd0, 1'b1, 32'h0000_4001, "R3 root wraps");

        // Random tables: level-1 slots 16..23, level-0 tables at 0x8000..0xB000.
        for (int i = 16; i < 24; i++) begin
            logic [31:0] r, p;
            r = $urandom;
            if (r[1:0] == 2'd0) begin
                p = mkpte(22'(8 + r[3:2]), {r[7:4], 3'b000, 1'b1});
            end else begin
                p = $urandom;
                if (r[5:4] != 2'd0) p[0] = 1'b1;
                if (r[6]) p[19:10] = 10'd0;
            end
            put(32'h1000 + i*4, p);
        end
        for (int t = 8; t < 12; t++) begin
            for (int j = 0; j < 8; j++) begin
                logic [31:0] p;
                p = $urandom;
                if (p[9:8] != 2'd0) p[0] = 1'b1;
                put(t*4096 + j*4, p);
            end
        end
        for (int k = 0; k < 400; k++) begin
            logic [31:0] va, r;
            r = $urandom;
            va = {10'(16 + r[2:0]), 10'(r[5:3]), r[17:6]};
            run(va, r[19:18], r[20], sp, "R10 random walk");
        end

        $display("CHECKS %0d ERRORS %0d", nchecks, nerrors);
        $finish;
    end

endmodule